// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array

This block holds a one-time-programmable fuse store in flip-flops. The store is split into `NUM_BANKS` banks of `BANK_BITS` bits each, so it forms `NUM_BANKS*BANK_BITS/32` rows of 32 bits. A programming port takes one flat bit index per request. The block can only ever set that bit. A fixed parameter list of guarded bit indices is compared against every request in parallel, and a request that hits an enabled entry is refused. The default configuration is three banks of 64 rows each, with four guard entries.

Whenever a program request actually turns a clear bit into a set bit, the block emits a one-cycle mirror strobe. The strobe carries the row index, the byte offset of that row in a little-endian external image, and the complete new row value. An external store can therefore shadow the array one 4-byte row at a time.

A registered read port returns a whole row. A preload port writes initial row contents, for example after power-up from a mirror. A bank size that is not a whole number of 32-bit rows stops elaboration with an error.

Top module: `otp_fuse_array`

## Requirements
- R1: A flat bit index `b` addresses row `b/32`, bit position `b%32` of that row. After a successful program, reading row `b/32` shows bit `b%32` set.
- R2: Programming only ORs one bit into its row. A program request never clears any bit and never changes any other bit.
- R3: A request whose index equals an enabled guard entry is refused. `prg_reject` is 1 in the cycle after the request, the row is unchanged, and no mirror strobe is raised. A guard entry whose enable bit is 0 protects nothing.
- R4: `upd_valid` pulses in the cycle after an accepted request only if the target bit was 0 beforehand. With it, `upd_row` is the row index and `upd_data` is the row after the set. Re-programming a set bit raises no strobe.
- R5: Every request that is not refused gives `prg_done`=1 in the following cycle, including when the bit was already set. `prg_done` and `prg_reject` are never both 1.
- R6: An index at or above `NUM_BANKS*BANK_BITS` is refused through `prg_reject` and changes no row.
- R7: During a strobe, `upd_offset` equals `upd_row*4`. Byte `k` (0..3) of the mirrored row, at offset `upd_offset+k`, is `upd_data[8k+7:8k]`.
- R8: `rd_data` is loaded with row `rd_row` at the edge where `rd_en` is 1 and holds otherwise. A program on that same edge is not yet visible.
- R9: `preload_en` overwrites row `preload_row` with `preload_data`, and the preload raises no strobe. A program request in the same cycle is dropped: no `prg_done`, no `prg_reject`, no change.
- R10: After reset every row reads 0, and `prg_done`, `prg_reject` and `upd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prg_valid | input | 1 | Program request |
| prg_bit | input | BIT_W | Flat bit index to program |
| prg_done | output | 1 | Request accepted (pulse) |
| prg_reject | output | 1 | Request refused: guarded or out of range (pulse) |
| upd_valid | output | 1 | Mirror update strobe |
| upd_row | output | ROW_W | Row index of the update |
| upd_offset | output | ROW_W+2 | Byte offset of the row in the mirror image |
| upd_data | output | 32 | New row value, byte k at offset+k |
| rd_en | input | 1 | Read request |
| rd_row | input | ROW_W | Row to read |
| rd_data | output | 32 | Registered row contents |
| preload_en | input | 1 | Preload strobe |
| preload_row | input | ROW_W | Row to preload |
| preload_data | input | 32 | Preload contents |

## Verification
The situation hardest to reach from the ports is a strobe on a bit that had already been set once. The array is set-only, so that can only happen after a preload clears the row again. The bench sweeps every index twice: the first pass covers each clear-to-set strobe and the second confirms that silent re-programs raise none. It then preloads a full row back to zero and programs a bit in it, expecting a fresh strobe. It also drives a preload and a program together, and a read and a program on the same edge, to pin down which one wins.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;
  localparam int unsigned ROW_BITS = 32;
  localparam int unsigned POS_W    = 5;

  function automatic logic [ROW_BITS-1:0] pos_mask(input logic [POS_W-1:0] pos);
    return {{(ROW_BITS-1){1'b0}}, 1'b1} << pos;
  endfunction

  function automatic logic [ROW_BITS-1:0] row_with_bit(input logic [ROW_BITS-1:0] row,
                                                       input logic [POS_W-1:0]    pos);
    return row | pos_mask(pos);
  endfunction

  function automatic logic bit_clear(input logic [ROW_BITS-1:0] row,
                                     input logic [POS_W-1:0]    pos);
    return (row & pos_mask(pos)) == '0;
  endfunction
endpackage

// File: rtl/otp_guard_match.sv
module otp_guard_match #(
  parameter int unsigned BIT_W   = 13,
  parameter int unsigned GUARD_N = 4,
  parameter logic [GUARD_N-1:0][31:0] GUARD_IDX = '0,
  parameter logic [GUARD_N-1:0]       GUARD_EN  = '0
) (
  input  logic [BIT_W-1:0] idx,
  output logic             hit
);
  logic [GUARD_N-1:0] hit_vec;

  for (genvar g = 0; g < GUARD_N; g++) begin : g_cmp
    assign hit_vec[g] = GUARD_EN[g] && (GUARD_IDX[g] == 32'(idx));
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/otp_row_store.sv
module otp_row_store #(
  parameter int unsigned ROWS  = 192,
  parameter int unsigned ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [31:0]      wr_data,
  input  logic             ld_en,
  input  logic [ROW_W-1:0] ld_row,
  input  logic [31:0]      ld_data,
  input  logic             rd_en,
  input  logic [ROW_W-1:0] rd_row,
  output logic [31:0]      rd_data,
  input  logic [ROW_W-1:0] peek_row,
  output logic [31:0]      peek_data
);
  localparam int unsigned SLOTS = 1 << ROW_W;

  logic [31:0] row_q   [ROWS];
  logic [31:0] row_ext [SLOTS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        row_q[r] <= '0;
      end else if (ld_en && ld_row == ROW_W'(r)) begin
        row_q[r] <= ld_data;
      end else if (wr_en && wr_row == ROW_W'(r)) begin
        row_q[r] <= wr_data;
      end
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_ext
    if (s < ROWS) begin : g_live
      assign row_ext[s] = row_q[s];
    end else begin : g_pad
      assign row_ext[s] = '0;
    end
  end

  assign peek_data = row_ext[peek_row];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= row_ext[rd_row];
    end
  end
endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_fuse_pkg::*;
#(
  parameter int unsigned BIT_W      = 13,
  parameter int unsigned ROW_W      = 8,
  parameter int unsigned TOTAL_BITS = 6144
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prg_valid,
  input  logic [BIT_W-1:0] prg_bit,
  input  logic             preload_en,
  input  logic             guard_hit,
  input  logic [31:0]      cur_row,
  output logic [ROW_W-1:0] sel_row,
  output logic             wr_en,
  output logic [31:0]      new_row,
  output logic             ev_take,
  output logic             ev_in_range,
  output logic             ev_was_clear,
  output logic             done_q,
  output logic             reject_q,
  output logic             upd_q,
  output logic [ROW_W-1:0] upd_row_q,
  output logic [31:0]      upd_data_q
);
  logic [POS_W-1:0] pos;
  logic             accept;

  assign sel_row      = ROW_W'(prg_bit >> POS_W);
  assign pos          = prg_bit[POS_W-1:0];
  assign ev_take      = prg_valid && !preload_en;
  assign ev_in_range  = prg_bit < BIT_W'(TOTAL_BITS);
  assign ev_was_clear = bit_clear(cur_row, pos);
  assign accept       = ev_take && ev_in_range && !guard_hit;
  assign new_row      = row_with_bit(cur_row, pos);
  assign wr_en        = accept && ev_was_clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q     <= 1'b0;
      reject_q   <= 1'b0;
      upd_q      <= 1'b0;
      upd_row_q  <= '0;
      upd_data_q <= '0;
    end else begin
      done_q   <= accept;
      reject_q <= ev_take && !accept;
      upd_q    <= wr_en;
      if (wr_en) begin
        upd_row_q  <= sel_row;
        upd_data_q <= new_row;
      end
    end
  end
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned BANK_BITS = 2048,
  parameter int unsigned GUARD_N   = 4,
  parameter logic [GUARD_N-1:0][31:0] GUARD_IDX = {32'd4095, 32'd2100, 32'd64, 32'd5},
  parameter logic [GUARD_N-1:0]       GUARD_EN  = 4'b0111,
  localparam int unsigned TOTAL_BITS = NUM_BANKS * BANK_BITS,
  localparam int unsigned ROWS       = TOTAL_BITS / 32,
  localparam int unsigned BIT_W      = $clog2(TOTAL_BITS + 1),
  localparam int unsigned ROW_W      = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prg_valid,
  input  logic [BIT_W-1:0] prg_bit,
  output logic             prg_done,
  output logic             prg_reject,
  output logic             upd_valid,
  output logic [ROW_W-1:0] upd_row,
  output logic [ROW_W+1:0] upd_offset,
  output logic [31:0]      upd_data,
  input  logic             rd_en,
  input  logic [ROW_W-1:0] rd_row,
  output logic [31:0]      rd_data,
  input  logic             preload_en,
  input  logic [ROW_W-1:0] preload_row,
  input  logic [31:0]      preload_data
);
  if (BANK_BITS == 0 || (BANK_BITS % 32) != 0) begin : g_bad_cfg
    $error("otp_fuse_array: BANK_BITS must be a non-zero multiple of 32");
  end

  logic             ev_guard_hit;
  logic             ev_take;
  logic             ev_in_range;
  logic             ev_was_clear;
  logic             ev_wr;
  logic [ROW_W-1:0] ev_row;
  logic [31:0]      ev_old_row;
  logic [31:0]      ev_new_row;

  otp_guard_match #(
    .BIT_W(BIT_W), .GUARD_N(GUARD_N), .GUARD_IDX(GUARD_IDX), .GUARD_EN(GUARD_EN)
  ) u_guard (
    .idx(prg_bit),
    .hit(ev_guard_hit)
  );

  otp_row_store #(.ROWS(ROWS), .ROW_W(ROW_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ev_wr), .wr_row(ev_row), .wr_data(ev_new_row),
    .ld_en(preload_en), .ld_row(preload_row), .ld_data(preload_data),
    .rd_en(rd_en), .rd_row(rd_row), .rd_data(rd_data),
    .peek_row(ev_row), .peek_data(ev_old_row)
  );

  otp_prog_ctrl #(.BIT_W(BIT_W), .ROW_W(ROW_W), .TOTAL_BITS(TOTAL_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .prg_valid(prg_valid), .prg_bit(prg_bit), .preload_en(preload_en),
    .guard_hit(ev_guard_hit), .cur_row(ev_old_row),
    .sel_row(ev_row), .wr_en(ev_wr), .new_row(ev_new_row),
    .ev_take(ev_take), .ev_in_range(ev_in_range), .ev_was_clear(ev_was_clear),
    .done_q(prg_done), .reject_q(prg_reject), .upd_q(upd_valid),
    .upd_row_q(upd_row), .upd_data_q(upd_data)
  );

  assign upd_offset = {upd_row, 2'b00};
endmodule

module otp_fuse_array_chk #(
  parameter int unsigned BIT_W      = 13,
  parameter int unsigned ROW_W      = 8,
  parameter int unsigned TOTAL_BITS = 6144
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prg_valid,
  input logic [BIT_W-1:0] prg_bit,
  input logic             preload_en,
  input logic             prg_done,
  input logic             prg_reject,
  input logic             upd_valid,
  input logic [ROW_W-1:0] upd_row,
  input logic [ROW_W+1:0] upd_offset,
  input logic [31:0]      upd_data,
  input logic             ev_guard_hit,
  input logic [31:0]      ev_old_row
);
  p_guard_refuses_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prg_valid && !preload_en && ev_guard_hit) |=> (prg_reject && !upd_valid));

  p_one_new_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> ($countones(upd_data ^ $past(ev_old_row)) == 1));

  p_strobe_needs_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> prg_done);

  p_done_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(prg_done && prg_reject));

  p_range_refuses_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (prg_valid && !preload_en && prg_bit >= BIT_W'(TOTAL_BITS)) |=> prg_reject);

  p_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (upd_offset == (ROW_W+2)'(upd_row) * 4));

  p_preload_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (prg_valid && preload_en) |=> (!prg_done && !prg_reject && !upd_valid));

  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !prg_valid |=> (!prg_done && !prg_reject));
endmodule

bind otp_fuse_array otp_fuse_array_chk #(
  .BIT_W(BIT_W), .ROW_W(ROW_W), .TOTAL_BITS(TOTAL_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .prg_valid(prg_valid), .prg_bit(prg_bit),
  .preload_en(preload_en), .prg_done(prg_done), .prg_reject(prg_reject),
  .upd_valid(upd_valid), .upd_row(upd_row), .upd_offset(upd_offset),
  .upd_data(upd_data), .ev_guard_hit(ev_guard_hit), .ev_old_row(ev_old_row)
);

// File: tb/otp_fuse_array_bench.sv
`timescale 1ns/1ps
module otp_fuse_array_bench;
  localparam int NB    = 3;
  localparam int BB    = 64;
  localparam int TOTAL = NB * BB;
  localparam int NROWS = TOTAL / 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prg_valid = 1'b0;
  logic [7:0]  prg_bit = '0;
  logic        prg_done, prg_reject, upd_valid;
  logic [2:0]  upd_row;
  logic [4:0]  upd_offset;
  logic [31:0] upd_data;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_row = '0;
  logic [31:0] rd_data;
  logic        preload_en = 1'b0;
  logic [2:0]  preload_row = '0;
  logic [31:0] preload_data = '0;

  always #4 clk = ~clk;

  otp_fuse_array #(
    .NUM_BANKS(NB), .BANK_BITS(BB), .GUARD_N(4),
    .GUARD_IDX({32'd77, 32'd130, 32'd40, 32'd3}),
    .GUARD_EN(4'b0111)
  ) u_otp_fuse_array (
    .clk(clk), .rst_n(rst_n), .prg_valid(prg_valid), .prg_bit(prg_bit),
    .prg_done(prg_done), .prg_reject(prg_reject), .upd_valid(upd_valid),
    .upd_row(upd_row), .upd_offset(upd_offset), .upd_data(upd_data),
    .rd_en(rd_en), .rd_row(rd_row), .rd_data(rd_data),
    .preload_en(preload_en), .preload_row(preload_row), .preload_data(preload_data)
  );

  int vectors = 0;
  int fails   = 0;
  logic [31:0] mdl [NROWS];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit guarded(input int idx);
    return idx == 3 || idx == 40 || idx == 130;
  endfunction

  task automatic read_row(input int r, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_row = 3'(r);
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rd_data, mdl[r]);
  endtask

  task automatic prog(input int idx);
    int r, p;
    bit ok, fresh;
    logic [31:0] nr;
    r = idx / 32; p = idx % 32;
    ok = (idx < TOTAL) && !guarded(idx);
    fresh = ok && (mdl[r][p] == 1'b0);
    nr = ok ? (mdl[r] | (32'h1 << p)) : 32'h0;
    @(negedge clk);
    prg_valid = 1'b1; prg_bit = 8'(idx);
    @(negedge clk);
    prg_valid = 1'b0;
    check(ok ? "R5 done" : (idx >= TOTAL ? "R6 range reject" : "R3 guard reject"),
          {prg_done, prg_reject}, {ok, !ok});
    check("R4 strobe", upd_valid, fresh);
    if (fresh) begin
      check("R4 row", upd_row, r);
      check("R4 data", upd_data, nr);
      check("R7 offset", upd_offset, r * 4);
      for (int k = 0; k < 4; k++)
        check("R7 byte", upd_data[8*k +: 8], (nr >> (8 * k)) & 32'hFF);
      mdl[r] = nr;
    end
    if (idx < TOTAL) read_row(r, ok ? "R1 R2 row" : "R3 row unchanged");
  endtask

  task automatic preload(input int r, input logic [31:0] d);
    @(negedge clk);
    preload_en = 1'b1; preload_row = 3'(r); preload_data = d;
    @(negedge clk);
    preload_en = 1'b0;
    check("R9 no strobe", {upd_valid, prg_done, prg_reject}, 3'b000);
    mdl[r] = d;
    read_row(r, "R9 preload");
  endtask

  initial begin
    for (int r = 0; r < NROWS; r++) mdl[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 pulses", {prg_done, prg_reject, upd_valid}, 3'b000);
    for (int r = 0; r < NROWS; r++) read_row(r, "R10 rows");

    // R8: read and program on the same edge
    @(negedge clk);
    rd_en = 1'b1; rd_row = 3'd0; prg_valid = 1'b1; prg_bit = 8'd9;
    @(negedge clk);
    rd_en = 1'b0; prg_valid = 1'b0;
    check("R8 old value", rd_data, 32'h0);
    check("R4 strobe bit9", {upd_valid, prg_done}, 2'b11);
    mdl[0] = 32'h200;
    read_row(0, "R8 new value");

    preload(1, 32'h0000_00F0);

    // R9: preload and program in the same cycle
    @(negedge clk);
    preload_en = 1'b1; preload_row = 3'd2; preload_data = 32'hA5A5_0000;
    prg_valid = 1'b1; prg_bit = 8'd69;
    @(negedge clk);
    preload_en = 1'b0; prg_valid = 1'b0;
    check("R9 dropped", {prg_done, prg_reject, upd_valid}, 3'b000);
    mdl[2] = 32'hA5A5_0000;
    read_row(2, "R9 collision row");

    for (int i = 0; i < TOTAL; i++) prog(i);
    for (int i = 0; i < TOTAL; i++) prog(i);
    for (int i = TOTAL; i < 256; i++) prog(i);

    // R3: guarded bits stay clear after both sweeps
    check("R3 bit3", mdl[0][3], 1'b0);
    read_row(4, "R3 row4 bit130 clear");

    // R4: re-cleared row gives a fresh strobe
    preload(3, 32'h0);
    prog(100);
    prog(100);
    prog(77);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule